// File: doc/BRIEF.md
# Four-Channel Stereo Volume Mixer

This block takes one signed 16-bit PCM sample from each of four voice channels in every sample period. It gives each channel's sample two gains, one for the left side and one for the right. Each gain is set by the channel's volume code plus that side's pan code, with one step per 2 dB of attenuation. A global option adds a further 6 dB attenuation per step. The block sums the scaled channels into a left mix and a right mix, clamps each sum to the 14-bit signed range and presents both words to the downstream converters together with a one-cycle valid pulse. Channels that are not active contribute zero signal. All channels share one sample rate.

A single signed multiplier is shared over the eight channel/side products of a period. A three-state machine runs this sequence:
- **ST_IDLE** waits for `sample_strobe`. On the strobe it latches the samples and copies the staged settings into the live settings. The transition is *idle→calc on strobe*.
- **ST_CALC** makes one product per cycle, in step order ch0-left, ch0-right, ch1-left and so on. The transition is *calc→finish after the last step*.
- **ST_FINISH** registers the clamped mixes and pulses `out_valid`. The transition is *finish→idle* and is unconditional.

Settings are written through a small register port into staging registers. They take effect at the next accepted strobe.

Top module: `stereo_vol_mixer`

## Requirements
- R1: Reset drives `mix_left`, `mix_right` and `out_valid` to 0. It clears every volume code, pan code and the global option to 0, so that after reset a lone active channel with sample s yields s>>>2 on both sides.
- R2: The gain for code sum k (0..30) is G(k) = round(256·10^(-k/10)), which is −2 dB per step, with G(0)=256. A channel's contribution to a side is floor(s·G(k)/2^(8+opt)).
- R3: For the left side, k = volume + left pan. For the right side, k = volume + right pan. Volume for channel n is written at address n (0–3) from data[3:0]. Pan for channel n is written at address 4+n, with the left code in data[7:4] and the right code in data[3:0].
- R4: The global option opt (0..3) is written at address 8 from data[1:0]. It divides every contribution by 2^opt, which is 6 dB per step.
- R5: Each side's sum is shifted right arithmetically by 2 and then clamped to [−8192, 8191] instead of wrapping.
- R6: A channel whose `chan_active` bit is low at the strobe contributes zero, whatever its sample.
- R7: `out_valid` is high for exactly one cycle, 9 clock edges after the edge that accepts the strobe. The mix outputs change only with that pulse.
- R8: A strobe that arrives while a period is being computed is ignored. It produces no extra result and does not disturb the current one.
- R9: A register write takes effect from the next accepted strobe, not in the period under way. Writes to addresses 9–15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_strobe | input | 1 | Starts a sample period when idle |
| sample_bus | input | 64 | Channel n sample in bits [16n+15:16n], two's complement |
| chan_active | input | 4 | Bit n high: channel n is playing |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_data | input | 8 | Register write data |
| mix_left | output | 14 | Left mix, signed |
| mix_right | output | 14 | Right mix, signed |
| out_valid | output | 1 | One-cycle pulse when a new mix is presented |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit samples, 14-bit outputs and a 4-bit register address. With these values every code sum from 0 to 30 can be reached, including the sums where the gain table rounds to zero, and every global option step can be reached. Four full-scale channels of the same sign push each side past both clamp rails. The 4-bit address also leaves seven unused addresses, so the bench can show that writes to them are ignored.

// File: rtl/mix_pkg.sv
package mix_pkg;
    localparam int CODE_W = 4;
    localparam int SUM_W  = CODE_W + 1;
    localparam int GAIN_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALC   = 2'd1,
        ST_FINISH = 2'd2
    } mix_state_t;
endpackage

// File: rtl/mix_gain_rom.sv
module mix_gain_rom import mix_pkg::*; (
    input  logic [SUM_W-1:0]  code,
    output logic [GAIN_W-1:0] gain
);
    // unsigned Q1.8 fractions, 256 = 0 dB, -2 dB per step
    always_comb begin
        case (code)
            5'd0:  gain = 9'd256;
            5'd1:  gain = 9'd203;
            5'd2:  gain = 9'd162;
            5'd3:  gain = 9'd128;
            5'd4:  gain = 9'd102;
            5'd5:  gain = 9'd81;
            5'd6:  gain = 9'd64;
            5'd7:  gain = 9'd51;
            5'd8:  gain = 9'd41;
            5'd9:  gain = 9'd32;
            5'd10: gain = 9'd26;
            5'd11: gain = 9'd20;
            5'd12: gain = 9'd16;
            5'd13: gain = 9'd13;
            5'd14: gain = 9'd10;
            5'd15: gain = 9'd8;
            5'd16: gain = 9'd6;
            5'd17: gain = 9'd5;
            5'd18: gain = 9'd4;
            5'd19: gain = 9'd3;
            5'd20: gain = 9'd3;
            5'd21: gain = 9'd2;
            5'd22: gain = 9'd2;
            5'd23: gain = 9'd1;
            5'd24: gain = 9'd1;
            5'd25: gain = 9'd1;
            5'd26: gain = 9'd1;
            5'd27: gain = 9'd1;
            default: gain = 9'd0;
        endcase
    end
endmodule

// File: rtl/mix_regs.sv
module mix_regs import mix_pkg::*; #(
    parameter int CH_NUM = 4,
    parameter int ADDR_W = 4,
    parameter int OPT_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [2*CODE_W-1:0]           wr_data,
    input  logic                          load,
    output logic [CH_NUM-1:0][CODE_W-1:0] vol_live,
    output logic [CH_NUM-1:0][CODE_W-1:0] panl_live,
    output logic [CH_NUM-1:0][CODE_W-1:0] panr_live,
    output logic [OPT_W-1:0]              opt_live
);
    // CH_NUM is a power of two: the low address bits pick the channel
    localparam int IDX_W = $clog2(CH_NUM);

    logic [CH_NUM-1:0][CODE_W-1:0] vol_sh, panl_sh, panr_sh;
    logic [OPT_W-1:0]              opt_sh;

    // staging registers, written from the register port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_sh  <= '0;
            panl_sh <= '0;
            panr_sh <= '0;
            opt_sh  <= '0;
        end else if (wr_en) begin
            if (wr_addr < ADDR_W'(CH_NUM)) begin
                vol_sh[wr_addr[IDX_W-1:0]] <= wr_data[CODE_W-1:0];
            end else if (wr_addr < ADDR_W'(2*CH_NUM)) begin
                panl_sh[wr_addr[IDX_W-1:0]] <= wr_data[2*CODE_W-1:CODE_W];
                panr_sh[wr_addr[IDX_W-1:0]] <= wr_data[CODE_W-1:0];
            end else if (wr_addr == ADDR_W'(2*CH_NUM)) begin
                opt_sh <= wr_data[OPT_W-1:0];
            end
        end
    end

    // live copy, refreshed only when a period starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_live  <= '0;
            panl_live <= '0;
            panr_live <= '0;
            opt_live  <= '0;
        end else if (load) begin
            vol_live  <= vol_sh;
            panl_live <= panl_sh;
            panr_live <= panr_sh;
            opt_live  <= opt_sh;
        end
    end

    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(vol_live) && $stable(panl_live) && $stable(panr_live) && $stable(opt_live))); // R9
endmodule

// File: rtl/mix_sat.sv
module mix_sat #(
    parameter int IN_W  = 19,
    parameter int OUT_W = 14,
    parameter int DROP  = 2
) (
    input  logic signed [IN_W-1:0]  acc,
    output logic signed [OUT_W-1:0] sat
);
    localparam logic signed [IN_W-1:0] HI = IN_W'((1 << (OUT_W-1)) - 1);
    localparam logic signed [IN_W-1:0] LO = IN_W'(-(1 << (OUT_W-1)));

    logic signed [IN_W-1:0] scaled;

    always_comb begin
        scaled = acc >>> DROP;
        if (scaled > HI)
            sat = HI[OUT_W-1:0];
        else if (scaled < LO)
            sat = LO[OUT_W-1:0];
        else
            sat = scaled[OUT_W-1:0];
    end
endmodule

// File: rtl/stereo_vol_mixer.sv
module stereo_vol_mixer import mix_pkg::*; #(
    parameter int CH_NUM   = 4,
    parameter int SAMPLE_W = 16,
    parameter int OUT_W    = 14,
    parameter int ADDR_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_strobe,
    input  logic [CH_NUM*SAMPLE_W-1:0] sample_bus,
    input  logic [CH_NUM-1:0]          chan_active,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [2*CODE_W-1:0]        reg_data,
    output logic signed [OUT_W-1:0]    mix_left,
    output logic signed [OUT_W-1:0]    mix_right,
    output logic                       out_valid
);
    localparam int STEP_W = $clog2(2*CH_NUM);
    localparam int CH_W   = STEP_W - 1;
    localparam int FRAC   = GAIN_W - 1;
    localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
    localparam int ACC_W  = SAMPLE_W + CH_W + 1;
    localparam int DROP   = SAMPLE_W - OUT_W;
    localparam int OPT_W  = 2;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(2*CH_NUM-1);
    localparam logic signed [ACC_W-1:0] OUT_MAX_A = ACC_W'((1 << (OUT_W-1)) - 1);
    localparam logic signed [ACC_W-1:0] OUT_MIN_A = ACC_W'(-(1 << (OUT_W-1)));

    logic [CH_NUM-1:0][CODE_W-1:0] vol_live, panl_live, panr_live;
    logic [OPT_W-1:0]              opt_live;
    logic                          load_live;

    mix_state_t                    st_q, st_d;
    logic [STEP_W-1:0]             step_q;
    logic signed [SAMPLE_W-1:0]    smp_q [CH_NUM];
    logic signed [ACC_W-1:0]       acc_q [2];
    logic signed [OUT_W-1:0]       sat_out [2];

    logic [CH_W-1:0]               ch_sel;
    logic                          side_sel;
    logic [SUM_W-1:0]              code_sum;
    logic [GAIN_W-1:0]             gain;
    logic signed [PROD_W-1:0]      prod;
    logic signed [ACC_W-1:0]       contrib;

    assign load_live = (st_q == ST_IDLE) && sample_strobe;

    mix_regs #(.CH_NUM(CH_NUM), .ADDR_W(ADDR_W), .OPT_W(OPT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_data), .load(load_live),
        .vol_live(vol_live), .panl_live(panl_live), .panr_live(panr_live),
        .opt_live(opt_live)
    );

    mix_gain_rom u_gain (.code(code_sum), .gain(gain));

    // one channel/side product per CALC cycle
    always_comb begin
        ch_sel   = step_q[STEP_W-1:1];
        side_sel = step_q[0];
        code_sum = {1'b0, vol_live[ch_sel]}
                 + {1'b0, (side_sel ? panr_live[ch_sel] : panl_live[ch_sel])};
        prod     = smp_q[ch_sel] * $signed({1'b0, gain});
        contrib  = ACC_W'(prod >>> (FRAC + int'(opt_live)));
    end

    for (genvar s = 0; s < 2; s++) begin : g_side
        mix_sat #(.IN_W(ACC_W), .OUT_W(OUT_W), .DROP(DROP)) u_sat (
            .acc(acc_q[s]), .sat(sat_out[s])
        );
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (sample_strobe) st_d = ST_CALC;
            ST_CALC:   if (step_q == LAST_STEP) st_d = ST_FINISH;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q    <= '0;
            for (int c = 0; c < CH_NUM; c++) smp_q[c] <= '0;
            acc_q[0]  <= '0;
            acc_q[1]  <= '0;
            mix_left  <= '0;
            mix_right <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (sample_strobe) begin
                        step_q   <= '0;
                        acc_q[0] <= '0;
                        acc_q[1] <= '0;
                        for (int c = 0; c < CH_NUM; c++)
                            smp_q[c] <= chan_active[c]
                                ? $signed(sample_bus[c*SAMPLE_W +: SAMPLE_W]) : '0;
                    end
                end
                ST_CALC: begin
                    acc_q[side_sel] <= acc_q[side_sel] + contrib;
                    step_q          <= step_q + STEP_W'(1);
                end
                ST_FINISH: begin
                    mix_left  <= sat_out[0];
                    mix_right <= sat_out[1];
                    out_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R7
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(mix_left) && $stable(mix_right))); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FINISH && (acc_q[0] >>> DROP) > OUT_MAX_A) |=> (mix_left == OUT_MAX_A[OUT_W-1:0])); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FINISH && (acc_q[1] >>> DROP) < OUT_MIN_A) |=> (mix_right == OUT_MIN_A[OUT_W-1:0])); // R5
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> !(st_q == ST_CALC && step_q == '0)); // R8
endmodule

// File: tb/sim_stereo_vol_mixer.sv
module sim_stereo_vol_mixer;
    localparam int NCH = 4;
    localparam int SW  = 16;
    localparam int OW  = 14;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   sample_strobe = 1'b0;
    logic [NCH*SW-1:0]      sample_bus = '0;
    logic [NCH-1:0]         chan_active = '0;
    logic                   reg_wr = 1'b0;
    logic [3:0]             reg_addr = '0;
    logic [7:0]             reg_data = '0;
    logic signed [OW-1:0]   mix_left, mix_right;
    logic                   out_valid;

    always #5 clk = ~clk;

    stereo_vol_mixer u0 (
        .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe),
        .sample_bus(sample_bus), .chan_active(chan_active),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data),
        .mix_left(mix_left), .mix_right(mix_right), .out_valid(out_valid)
    );

    int checks = 0;
    int errors = 0;
    int sh_vol[NCH], sh_pl[NCH], sh_pr[NCH], sh_opt;
    int lv_vol[NCH], lv_pl[NCH], lv_pr[NCH], lv_opt;
    int s_in[NCH];
    logic [NCH-1:0] act_in;
    int exp_l, exp_r;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int gref(int k);
        real r;
        if (k > 30) return 0;
        r = 256.0 * (10.0 ** (-k / 10.0));
        return $rtoi(r + 0.5);
    endfunction

    function automatic int side_ref(int side);
        longint acc = 0;
        for (int c = 0; c < NCH; c++) begin
            if (act_in[c]) begin
                int k = lv_vol[c] + ((side != 0) ? lv_pr[c] : lv_pl[c]);
                longint p = longint'(s_in[c]) * longint'(gref(k));
                acc += p >>> (8 + lv_opt);
            end
        end
        acc = acc >>> 2;
        if (acc > 8191) acc = 8191;
        if (acc < -8192) acc = -8192;
        return int'(acc);
    endfunction

    function automatic void shadow_update(int a, int d);
        if (a < 4) sh_vol[a] = d & 15;
        else if (a < 8) begin
            sh_pl[a-4] = (d >> 4) & 15;
            sh_pr[a-4] = d & 15;
        end else if (a == 8) sh_opt = d & 3;
    endfunction

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a[3:0];
        reg_data = d[7:0];
        shadow_update(a, d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run(string req, bit mid_wr, int ma, int md, bit busy);
        int n = 0;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) sample_bus[c*SW +: SW] = s_in[c][SW-1:0];
        chan_active = act_in;
        sample_strobe = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            lv_vol[c] = sh_vol[c]; lv_pl[c] = sh_pl[c]; lv_pr[c] = sh_pr[c];
        end
        lv_opt = sh_opt;
        exp_l = side_ref(0);
        exp_r = side_ref(1);
        @(posedge clk);
        @(negedge clk);
        sample_strobe = 1'b0;
        while (!out_valid && n < 30) begin
            if (mid_wr && n == 3) begin
                reg_wr = 1'b1; reg_addr = ma[3:0]; reg_data = md[7:0];
                shadow_update(ma, md);
            end
            if (busy && n == 3) begin
                sample_strobe = 1'b1;
                sample_bus = ~sample_bus;
            end
            @(posedge clk);
            @(negedge clk);
            reg_wr = 1'b0;
            sample_strobe = 1'b0;
            n++;
        end
        check("R7 latency", n, 9);
        check({req, " left"}, int'(mix_left), exp_l);
        check({req, " right"}, int'(mix_right), exp_r);
        @(posedge clk);
        @(negedge clk);
        check("R7 single pulse", int'(out_valid), 0);
        check("R7 hold", int'(mix_left), exp_l);
        if (busy) begin
            int seen = 0;
            repeat (12) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            check("R8 busy strobe ignored", seen, 0);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int c = 0; c < NCH; c++) begin
            sh_vol[c] = 0; sh_pl[c] = 0; sh_pr[c] = 0; s_in[c] = 0;
        end
        sh_opt = 0;
        act_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset left", int'(mix_left), 0);
        check("R1 reset right", int'(mix_right), 0);
        check("R1 reset valid", int'(out_valid), 0);
        rst_n = 1'b1;

        // R1: codes cleared by reset -> 0 dB
        s_in[0] = 4000; act_in = 4'b0001;
        run("R1 default gain", 0, 0, 0, 0);
        check("R1 direct value", int'(mix_left), 1000);

        // R2: volume code 3 -> gain 128
        wr(0, 3);
        run("R2 volume", 0, 0, 0, 0);
        check("R2 direct value", int'(mix_left), 500);

        // R3: separate left/right pan
        wr(4, 8'h25);
        wr(5, 8'h0F);
        wr(1, 1);
        s_in[0] = -3000; s_in[1] = 12000; act_in = 4'b0011;
        run("R3 pan", 0, 0, 0, 0);

        // R2: deep code sums reach table zeros
        wr(2, 15); wr(6, 8'hFF);
        s_in[2] = 32000; act_in = 4'b0100;
        run("R2 deep attenuation", 0, 0, 0, 0);

        // R4: global option steps
        for (int o = 0; o < 4; o++) begin
            wr(8, o);
            s_in[0] = 20000; s_in[1] = -7000; s_in[2] = 9000; s_in[3] = -123;
            act_in = 4'b1111;
            run("R4 option", 0, 0, 0, 0);
        end

        // R5: clamp both rails
        for (int c = 0; c < NCH; c++) begin wr(c, 0); wr(4 + c, 0); end
        wr(8, 0);
        for (int c = 0; c < NCH; c++) s_in[c] = 32767;
        act_in = 4'b1111;
        run("R5 clamp high", 0, 0, 0, 0);
        check("R5 direct high", int'(mix_left), 8191);
        for (int c = 0; c < NCH; c++) s_in[c] = -32768;
        run("R5 clamp low", 0, 0, 0, 0);
        check("R5 direct low", int'(mix_right), -8192);
        for (int c = 0; c < NCH; c++) s_in[c] = 20000;
        run("R5 clamp partial", 0, 0, 0, 0);

        // R6: inactive channels ignored
        s_in[0] = 1000; s_in[1] = 32767; s_in[2] = -2000; s_in[3] = -32768;
        act_in = 4'b0101;
        run("R6 inactive", 0, 0, 0, 0);
        check("R6 direct value", int'(mix_left), -250);

        // R8: strobe while busy
        run("R8 busy", 0, 0, 0, 1);

        // R9: mid-period write applies from next period
        act_in = 4'b1111;
        run("R9 old setting", 1, 0, 7, 0);
        run("R9 new setting", 0, 0, 0, 0);
        wr(9, 8'hFF); wr(12, 8'h33); wr(15, 8'hA5);
        run("R9 unused address", 0, 0, 0, 0);

        // random periods
        for (int i = 0; i < 40; i++) begin
            repeat (int'($urandom_range(0, 3)))
                wr(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)));
            for (int c = 0; c < NCH; c++) s_in[c] = int'($urandom_range(0, 65535)) - 32768;
            act_in = 4'($urandom_range(0, 15));
            run("R2 random", 0, 0, 0, 0);
        end

        finish_run();
    end
endmodule